// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block collects 32 maskable interrupt lines into a single prioritised IRQ output and two more lines into a fast-interrupt (FIQ) output. Every IRQ channel has an enable bit, a sticky pending bit, a 4-bit priority and a 16-bit vector half. A combinational arbiter finds the enabled, pending channel with the highest priority. IRQ is raised only when that priority is strictly above the priority now being serviced.

Software reads the vector register to acknowledge an interrupt. The read returns a 32-bit vector made of a shared base half and the winning channel's half. The same read saves the current priority on a hardware stack and loads the winner's priority as the new current priority. A later write that clears pending bits restores the saved priority. This lets a higher-priority interrupt nest inside a lower one, up to fifteen levels deep. The two fast channels have no priority and no vector. Each one only asks for FIQ while it is enabled and pending.

The stack is controlled by a state machine with three states. STK_EMPTY means no level is saved. STK_NESTED means at least one level is saved and there is room for more. STK_FULL means all saved slots are used. Its transitions are as follows. A push moves STK_EMPTY to STK_NESTED. A push moves STK_NESTED to STK_FULL when it fills the last slot. A pop moves STK_NESTED to STK_EMPTY when it removes the last saved level. A pop moves STK_FULL to STK_NESTED. Every other case holds the present state.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, all enables, pending bits, priorities, the global enables and the current priority are zero, and irq_o and fiq_o are low.
- R2: An IRQ pending bit (register 0x04, bit n = channel n) is set while its input line is high and stays set until software writes 1 to it. If the line is high in the same cycle as the clearing write, the bit stays set.
- R3: irq_o is high exactly when the IRQ global enable (register 0x00 bit 0) is set and some channel that is enabled (register 0x03, bit n) and pending has a priority strictly above the current priority. A channel with priority 0 never raises irq_o.
- R4: When several qualifying channels share the highest priority, the lowest-numbered channel wins.
- R5: A read of the vector register (0x02) returns the base half (written through bits 31:16 of a write to 0x02) in bits 31:16. Bits 15:0 hold the winner's vector half, or zero when no channel qualifies as in R3 (ignoring the global enable).
- R6: A vector read with a qualifying winner saves the current priority and makes the winner's priority the current priority, which reads back at register 0x01 bits 3:0. A vector read with no winner changes nothing.
- R7: A write to 0x04 with any bit set restores the most recently saved priority as the current priority. When nothing is saved, the current priority becomes 0.
- R8: Up to 15 levels nest, and they are restored in last-in, first-out order.
- R9: fiq_o is high exactly when the FIQ global enable (register 0x00 bit 1) is set and some fast channel is both enabled and pending. Fast interrupts never change the current priority.
- R10: Register 0x05 holds the fast enables in bits 1:0 and the fast pending bits in bits 3:2. A fast pending bit is set by its line. Writing 1 to bits 3:2 clears the matching pending bits, and the write also loads bits 1:0 as the enables.
- R11: Channel n's configuration is at address 0x20+n. It holds the vector half in bits 31:16 and the priority in bits 3:0, reads back as written, and reads zero in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | IRQ source lines, level sensitive |
| fast_lines | input | 2 | Fast-interrupt source lines |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe (side effect only for the vector register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Prioritised interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two functions can meet in one cycle: a source line setting a pending bit and the software write that clears that bit and pops the stack. The bench holds channel 3's line high on the same clock edge that software writes 1 to its pending bit. After that edge it checks three things: the bit is still set, the stack has popped to priority 0, and irq_o is high again because the still-pending channel now outranks the restored level. The nesting sweep separately drives the stack through all fifteen levels and back.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] A_CUR  = 6'h01;
    localparam logic [ADDR_W-1:0] A_VEC  = 6'h02;
    localparam logic [ADDR_W-1:0] A_EN   = 6'h03;
    localparam logic [ADDR_W-1:0] A_PEND = 6'h04;
    localparam logic [ADDR_W-1:0] A_FAST = 6'h05;

    typedef enum logic [1:0] {
        STK_EMPTY,
        STK_NESTED,
        STK_FULL
    } stk_state_t;

endpackage

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter #(
    parameter int NUM_CH = 32,
    parameter int PRIO_W = 4,
    localparam int ID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0]        elig,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic                     win_valid,
    output logic [ID_W-1:0]          win_id,
    output logic [PRIO_W-1:0]        win_pri
);

    // Strict "greater than" keeps the first (lowest) channel on ties,
    // and a zero priority can never replace the zero starting value.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_pri   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (elig[i] && (prio_flat[i*PRIO_W +: PRIO_W] > win_pri)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                win_pri   = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack
    import nest_irq_pkg::*;
#(
    parameter int PRIO_W  = 4,
    parameter int LEVELS  = 16,
    localparam int SAVE    = LEVELS - 1,
    localparam int DEPTH_W = $clog2(LEVELS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic [PRIO_W-1:0]  push_pri,
    output logic [PRIO_W-1:0]  cur_pri,
    output logic [DEPTH_W-1:0] depth
);

    stk_state_t state, state_nxt;
    logic [PRIO_W-1:0] saved [0:SAVE-1];
    logic push_ok;
    logic pop_live;

    assign push_ok  = push && (state != STK_FULL);
    assign pop_live = pop && !push_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= STK_EMPTY;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            STK_EMPTY: begin
                if (push_ok) state_nxt = (SAVE == 1) ? STK_FULL : STK_NESTED;
            end
            STK_NESTED: begin
                if (push_ok && depth == DEPTH_W'(SAVE - 1))
                    state_nxt = STK_FULL;
                else if (pop_live && depth == DEPTH_W'(1))
                    state_nxt = STK_EMPTY;
            end
            STK_FULL: begin
                if (pop_live) state_nxt = (SAVE == 1) ? STK_EMPTY : STK_NESTED;
            end
            default: state_nxt = STK_EMPTY;
        endcase
    end

    // datapath driven by the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pri <= '0;
            depth   <= '0;
            for (int i = 0; i < SAVE; i++) saved[i] <= '0;
        end else if (push_ok) begin
            saved[depth] <= cur_pri;
            cur_pri      <= push_pri;
            depth        <= depth + DEPTH_W'(1);
        end else if (pop_live) begin
            if (state == STK_EMPTY) begin
                cur_pri <= '0;
            end else begin
                cur_pri <= saved[depth - DEPTH_W'(1)];
                depth   <= depth - DEPTH_W'(1);
            end
        end
    end

    assert_push_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (cur_pri > $past(cur_pri)));

    assert_pop_unwinds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_live && depth != '0) |=> (depth == $past(depth) - DEPTH_W'(1)));

    assert_empty_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STK_EMPTY) == (depth == '0));

endmodule

// File: rtl/nest_irq_fast.sv
module nest_irq_fast #(
    parameter int NUM_FAST = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FAST-1:0] lines,
    input  logic                cfg_wr,
    input  logic [NUM_FAST-1:0] cfg_en,
    input  logic [NUM_FAST-1:0] cfg_clr,
    input  logic                gen,
    output logic [NUM_FAST-1:0] en,
    output logic [NUM_FAST-1:0] pend,
    output logic                fiq
);

    logic [NUM_FAST-1:0] clr_mask;

    assign clr_mask = cfg_wr ? cfg_clr : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= '0;
            pend <= '0;
        end else begin
            if (cfg_wr) en <= cfg_en;
            pend <= (pend & ~clr_mask) | lines;
        end
    end

    assign fiq = gen && |(en & pend);

    assert_fiq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fiq |-> (|(pend & en)));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nest_irq_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int PRIO_W   = 4,
    parameter int LEVELS   = 16,
    parameter int NUM_FAST = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         irq_lines,
    input  logic [1:0]          fast_lines,
    input  logic [5:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq_o,
    output logic                fiq_o
);

    localparam int ID_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int DEPTH_W = $clog2(LEVELS);
    localparam int PAD_W   = 16 - PRIO_W;

    logic                     g_irq_en, g_fiq_en;
    logic [15:0]              vec_base;
    logic [NUM_CH-1:0]        ier, ipr;
    logic [PRIO_W-1:0]        ch_pri [NUM_CH];
    logic [15:0]              ch_vec [NUM_CH];
    logic [NUM_CH*PRIO_W-1:0] prio_flat;

    logic                     win_valid;
    logic [ID_W-1:0]          win_id;
    logic [PRIO_W-1:0]        win_pri;
    logic [PRIO_W-1:0]        cur_pri;
    logic [DEPTH_W-1:0]       depth;
    logic                     above;
    logic                     push, pop;
    logic [NUM_CH-1:0]        pend_clr;
    logic [NUM_FAST-1:0]      f_en, f_pend;
    logic                     f_fiq;

    logic wr_ctrl, wr_vec, wr_en, wr_pend, wr_fast, rd_vec;
    logic [31:0] vec_word;

    assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
    assign wr_vec  = bus_wr && bus_addr == A_VEC;
    assign wr_en   = bus_wr && bus_addr == A_EN;
    assign wr_pend = bus_wr && bus_addr == A_PEND;
    assign wr_fast = bus_wr && bus_addr == A_FAST;
    assign rd_vec  = bus_rd && !bus_wr && bus_addr == A_VEC;

    // global control, base and enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_irq_en <= 1'b0;
            g_fiq_en <= 1'b0;
            vec_base <= '0;
            ier      <= '0;
        end else begin
            if (wr_ctrl) begin
                g_irq_en <= bus_wdata[0];
                g_fiq_en <= bus_wdata[1];
            end
            if (wr_vec) vec_base <= bus_wdata[31:16];
            if (wr_en)  ier      <= bus_wdata[NUM_CH-1:0];
        end
    end

    // pending: line sets, write-one clears, set wins
    assign pend_clr = wr_pend ? bus_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) ipr <= '0;
        else        ipr <= (ipr & ~pend_clr) | irq_lines[NUM_CH-1:0];
    end

    // per-channel configuration
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic sel;
        assign sel = bus_wr && bus_addr[5] && (bus_addr[4:0] == 5'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_pri[g] <= '0;
                ch_vec[g] <= '0;
            end else if (sel) begin
                ch_pri[g] <= bus_wdata[PRIO_W-1:0];
                ch_vec[g] <= bus_wdata[31:16];
            end
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = ch_pri[g];
    end

    nest_irq_arbiter #(
        .NUM_CH (NUM_CH),
        .PRIO_W (PRIO_W)
    ) u_arb (
        .elig      (ier & ipr),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_pri   (win_pri)
    );

    assign above = win_valid && (win_pri > cur_pri);
    assign push  = rd_vec && above;
    assign pop   = wr_pend && |bus_wdata[NUM_CH-1:0];

    nest_irq_stack #(
        .PRIO_W (PRIO_W),
        .LEVELS (LEVELS)
    ) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_pri (win_pri),
        .cur_pri  (cur_pri),
        .depth    (depth)
    );

    nest_irq_fast #(
        .NUM_FAST (NUM_FAST)
    ) u_fast (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (fast_lines[NUM_FAST-1:0]),
        .cfg_wr  (wr_fast),
        .cfg_en  (bus_wdata[NUM_FAST-1:0]),
        .cfg_clr (bus_wdata[2*NUM_FAST-1:NUM_FAST]),
        .gen     (g_fiq_en),
        .en      (f_en),
        .pend    (f_pend),
        .fiq     (f_fiq)
    );

    assign irq_o = g_irq_en && above;
    assign fiq_o = f_fiq;

    assign vec_word = above ? {vec_base, ch_vec[win_id]} : {vec_base, 16'h0000};

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[5]) begin
            if (32'(bus_addr[4:0]) < NUM_CH)
                bus_rdata = {ch_vec[bus_addr[ID_W-1:0]], {PAD_W{1'b0}},
                             ch_pri[bus_addr[ID_W-1:0]]};
        end else begin
            case (bus_addr)
                A_CTRL:  bus_rdata = {30'd0, g_fiq_en, g_irq_en};
                A_CUR:   bus_rdata = {{(32-PRIO_W){1'b0}}, cur_pri};
                A_VEC:   bus_rdata = vec_word;
                A_EN:    bus_rdata = 32'(ier);
                A_PEND:  bus_rdata = 32'(ipr);
                A_FAST:  bus_rdata = 32'({f_pend, f_en});
                default: bus_rdata = '0;
            endcase
        end
    end

    logic unused_bits;
    assign unused_bits = ^{bus_wdata, irq_lines, fast_lines, depth};

    assert_pend_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend |=> ((ipr & $past(ipr)) == $past(ipr)));

    assert_push_loads_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (cur_pri == $past(win_pri)));

endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic [1:0]  fast_lines = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_err = 0;
    localparam logic [15:0] BASE = 16'h5A5A;

    always #2.5 clk = ~clk;

    nest_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .fast_lines(fast_lines),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [3:0] pri_of(int ch);
        return 4'((ch % 15) + 1);
    endfunction

    function automatic logic [15:0] vec_of(int ch);
        return 16'hA000 + 16'(ch * 7);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic read_vec(output logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'h02; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_irq(logic [31:0] m);
        @(negedge clk);
        irq_lines = m;
        @(negedge clk);
        irq_lines = '0;
    endtask

    task automatic pulse_fast(logic [1:0] m);
        @(negedge clk);
        fast_lines = m;
        @(negedge clk);
        fast_lines = '0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 irq_o", 32'(irq_o), 0);
        chk("R1 fiq_o", 32'(fiq_o), 0);
        peek(6'h01, d); chk("R1 cur", d, 0);
        peek(6'h03, d); chk("R1 enable", d, 0);
        peek(6'h04, d); chk("R1 pending", d, 0);
        peek(6'h00, d); chk("R1 ctrl", d, 0);

        bus_write(6'h00, 32'h3);
        bus_write(6'h02, {BASE, 16'h0});
        for (int ch = 0; ch < 32; ch++)
            bus_write(6'(32 + ch), {vec_of(ch), 12'h0, pri_of(ch)});
        // R11 readback
        for (int ch = 0; ch < 32; ch += 5) begin
            peek(6'(32 + ch), d);
            chk("R11 channel cfg", d, {vec_of(ch), 12'h0, pri_of(ch)});
        end

        // per-channel sweep: R2 R3 R5 R6 R7
        for (int ch = 0; ch < 32; ch++) begin
            bus_write(6'h03, 32'(1) << ch);
            pulse_irq(32'(1) << ch);
            #1 chk("R3 irq raised", 32'(irq_o), 1);
            peek(6'h04, d); chk("R2 pending latched", d, 32'(1) << ch);
            read_vec(d); chk("R5 vector", d, {BASE, vec_of(ch)});
            peek(6'h01, d); chk("R6 cur loaded", d, 32'(pri_of(ch)));
            chk("R3 irq off at equal prio", 32'(irq_o), 0);
            bus_write(6'h04, 32'(1) << ch);
            peek(6'h01, d); chk("R7 popped", d, 0);
            peek(6'h04, d); chk("R2 cleared", d, 0);
        end

        // R3 global gate
        bus_write(6'h00, 32'h2);
        bus_write(6'h03, 32'h10);
        pulse_irq(32'h10);
        #1 chk("R3 gated off", 32'(irq_o), 0);
        bus_write(6'h00, 32'h3);
        #1 chk("R3 gate on", 32'(irq_o), 1);
        bus_write(6'h04, 32'h10);
        peek(6'h01, d); chk("R7 pop when empty", d, 0);

        // priority 0 channel
        bus_write(6'h20, {16'hBEEF, 16'h0000});
        bus_write(6'h03, 32'h1);
        pulse_irq(32'h1);
        #1 chk("R3 prio zero silent", 32'(irq_o), 0);
        read_vec(d); chk("R5 no winner vector", d, {BASE, 16'h0});
        peek(6'h01, d); chk("R6 no push", d, 0);
        bus_write(6'h04, 32'h1);

        // R4 tie between 5 and 9
        bus_write(6'h25, {vec_of(5), 16'h0007});
        bus_write(6'h29, {vec_of(9), 16'h0007});
        bus_write(6'h03, 32'h220);
        pulse_irq(32'h220);
        read_vec(d); chk("R4 tie lowest", d, {BASE, vec_of(5)});
        peek(6'h01, d); chk("R4 tie prio", d, 7);
        bus_write(6'h04, 32'h220);
        peek(6'h01, d); chk("R7 single pop", d, 0);
        peek(6'h04, d); chk("R2 both cleared", d, 0);

        // R8 fifteen nested levels
        for (int k = 1; k <= 15; k++)
            bus_write(6'(32 + k), {vec_of(k), 12'h0, 4'(k)});
        bus_write(6'h03, 32'h0000FFFE);
        for (int k = 1; k <= 15; k++) begin
            pulse_irq(32'(1) << k);
            #1 chk("R8 nest irq", 32'(irq_o), 1);
            read_vec(d); chk("R8 nest vector", d, {BASE, vec_of(k)});
            peek(6'h01, d); chk("R8 nest cur", d, 32'(k));
        end
        chk("R8 top level quiet", 32'(irq_o), 0);
        for (int k = 15; k >= 1; k--) begin
            bus_write(6'h04, 32'(1) << k);
            peek(6'h01, d); chk("R8 unwind", d, 32'(k - 1));
            chk("R8 unwind quiet", 32'(irq_o), 0);
        end

        // R2 collision: line high while software clears
        bus_write(6'h23, {vec_of(3), 16'h0009});
        bus_write(6'h03, 32'h8);
        pulse_irq(32'h8);
        read_vec(d);
        peek(6'h01, d); chk("R6 cur nine", d, 9);
        @(negedge clk);
        irq_lines = 32'h8; bus_addr = 6'h04; bus_wdata = 32'h8; bus_wr = 1'b1;
        @(negedge clk);
        irq_lines = '0; bus_wr = 1'b0;
        peek(6'h04, d); chk("R2 set wins", d, 32'h8);
        peek(6'h01, d); chk("R7 pop on collision", d, 0);
        chk("R3 re-raised", 32'(irq_o), 1);
        bus_write(6'h04, 32'h8);
        peek(6'h04, d); chk("R2 final clear", d, 0);
        bus_write(6'h03, 32'h0);

        // fast path R9 R10
        bus_write(6'h05, 32'h1);
        pulse_fast(2'b10);
        #1 chk("R9 disabled fast quiet", 32'(fiq_o), 0);
        peek(6'h05, d); chk("R10 fast reg", d, 32'h9);
        pulse_fast(2'b01);
        #1 chk("R9 fiq raised", 32'(fiq_o), 1);
        peek(6'h01, d); chk("R9 cur untouched", d, 0);
        chk("R9 no irq", 32'(irq_o), 0);
        bus_write(6'h00, 32'h1);
        #1 chk("R9 gated", 32'(fiq_o), 0);
        bus_write(6'h00, 32'h3);
        #1 chk("R9 ungated", 32'(fiq_o), 1);
        bus_write(6'h05, 32'h5);
        #1 chk("R10 cleared fiq", 32'(fiq_o), 0);
        peek(6'h05, d); chk("R10 other pend kept", d, 32'h9);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule